// File: doc/BRIEF.md
# Auxiliary Sideband Channel Transaction Engine

This block runs request/reply transactions on one auxiliary sideband channel. Software stages up to twenty outgoing bytes in five 32-bit data words. It then writes a control word with the start bit set. The engine emits a sync pattern on `line_sync` for a programmable number of pulses, each pulse lasting a programmable number of clock cycles. It then streams the staged bytes over a byte-wide valid/ready link with first and last markers, and waits for the reply.

Reply bytes are written back into the same buffer from byte 0 upward. The transaction ends in one of two ways: a reply byte flagged last, or a selectable timeout. The control word then reports completion, error flags and the number of reply bytes received. Line coding and the analog pad belong to the neighbouring logic.

Register map (`reg_addr`): 0 is the control/status word, 1 to 5 are data words 0 to 4, and addresses 6 and 7 read as zero. Control word fields:

- bit 31: start/busy
- bit 30: done
- bit 29: interrupt enable
- bit 28: timeout error
- bits 27:26: timeout select
- bit 25: receive error
- bits 24:20: size
- bit 19: fast-wake sync
- bits 16:15: extra precharge
- bits 7:0: pulse divider

All other bits read zero.

Top module: `auxch_ctrl`

## Requirements
- R1: After reset the control word and every data word read 0, and `tx_valid`, `line_sync` and `irq` are low.
- R2: Buffer byte b lives in data word b/4, with byte 0 of each word in bits 31:24 (most significant byte first). The engine sends bytes 0 to size-1 in that order, with `tx_first` on byte 0 only and `tx_last` on byte size-1 only, and holds each byte until `tx_ready`.
- R3: Before the first byte, `line_sync` is high for pulses times divider cycles. A divider of 0 acts as 1. Pulses are 26 + 2·extra-precharge in the normal mode (26 to 32), and 18 when the fast-wake bit is set.
- R4: Bit 31 reads 1 from the start write until the transaction ends. Writes to any register while busy are ignored.
- R5: Reply bytes are stored from buffer byte 0 in the R2 order, and bytes not reached keep their value. On the reply byte marked `rx_last`, the engine sets done, clears busy and places the reply byte count in the size field.
- R6: If no reply ends within the selected window after the last byte is sent, the engine sets done and timeout error and clears busy. The window counts from the end of the send: select 00 gives TO_SHORT cycles, 01 gives TO_MID cycles, and 1x gives TO_MAX cycles.
- R7: A reply containing a byte flagged `rx_bad`, or more than 20 bytes, ends with receive error set. Bytes past 20 are dropped, and the size field then reads 21.
- R8: Writing 1 to bit 30, 28 or 25 clears that status bit. Writing 0 leaves it unchanged.
- R9: When interrupt enable is set, `irq` is high for exactly one cycle, in the cycle done is set. When interrupt enable is clear, `irq` stays low.
- R10: A start with size 0 or size above 20 sends nothing and produces no sync. On the next cycle it sets done and receive error with busy clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1..5 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | One-cycle completion interrupt |
| line_sync | output | 1 | High while the sync pattern is emitted |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Link accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_first | output | 1 | Outgoing byte is the first of the message |
| tx_last | output | 1 | Outgoing byte is the last of the message |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_bad | input | 1 | Reply byte was malformed on the line |
| rx_last | input | 1 | Reply byte ends the reply |

## Verification
The assertions assume that the link side only presents reply bytes while the engine is waiting for one. They also assume that `tx_ready` is a plain accept, and that nothing outside the register port alters the buffer. The stimulus keeps to this. It raises `rx_valid` only after the last outgoing byte has been observed. It issues register writes during a transaction only to check that they are dropped. It always holds `tx_ready` high, so the hold property is checked only in its vacuous form.

// File: rtl/auxch_pkg.sv
package auxch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_SEND = 2'd2,
        ST_WAIT = 2'd3
    } auxch_st_e;

    localparam int SZ_W        = 5;
    localparam int PULSE_W     = 6;
    localparam int FAST_PULSES = 18;
    localparam int BASE_PULSES = 26;
endpackage

// File: rtl/auxch_tick.sv
module auxch_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        lim  = (div == '0) ? DIV_W'(1) : div;
        tick = en && (cnt_q == lim - DIV_W'(1));
        if (clr)
            cnt_d = '0;
        else if (en)
            cnt_d = tick ? '0 : cnt_q + DIV_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/auxch_buf.sv
module auxch_buf #(
    parameter int NWORDS = 5,
    parameter int IW     = 3,
    parameter int BIW    = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we,
    input  logic [IW-1:0]  sw_idx,
    input  logic [31:0]    sw_data,
    input  logic [IW-1:0]  rd_idx,
    output logic [31:0]    rd_word,
    input  logic           eng_we,
    input  logic [BIW-1:0] eng_idx,
    input  logic [7:0]     eng_data,
    output logic [7:0]     eng_byte
);
    logic [NWORDS-1:0][31:0] mem_d, mem_q;
    logic [BIW-1:0]          eng_word;
    logic [1:0]              eng_lane;

    assign eng_word = eng_idx >> 2;
    assign eng_lane = eng_idx[1:0];

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < NWORDS; w++) begin
            if (sw_we && int'(sw_idx) == w)
                mem_d[w] = sw_data;
            else if (eng_we && int'(eng_word) == w)
                mem_d[w][8*(3-int'(eng_lane)) +: 8] = eng_data;
        end
        rd_word  = (int'(rd_idx) < NWORDS) ? mem_q[rd_idx] : '0;
        eng_byte = (int'(eng_word) < NWORDS) ? mem_q[eng_word][8*(3-int'(eng_lane)) +: 8] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end
endmodule

// File: rtl/auxch_ctrl.sv
module auxch_ctrl #(
    parameter int NWORDS   = 5,
    parameter int DIV_W    = 8,
    parameter int TO_SHORT = 400,
    parameter int TO_MID   = 600,
    parameter int TO_MAX   = 1600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        line_sync,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_first,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_bad,
    input  logic        rx_last
);
    import auxch_pkg::*;

    localparam int BYTES = NWORDS * 4;
    localparam int IW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int TMR_W = $clog2(TO_MAX + 1);

    typedef struct packed {
        auxch_st_e          st;
        logic               done;
        logic               to_err;
        logic               rx_err;
        logic               irq_en;
        logic               fast;
        logic               bad;
        logic               irq;
        logic [1:0]         to_sel;
        logic [1:0]         pre;
        logic [SZ_W-1:0]    size;
        logic [SZ_W-1:0]    idx;
        logic [DIV_W-1:0]   div;
        logic [PULSE_W-1:0] pulses;
        logic [TMR_W-1:0]   timer;
    } regs_t;

    regs_t r_d, r_q;

    logic               tick, sw_we, eng_we, size_ok, busy;
    logic [31:0]        word_rd;
    logic [7:0]         eng_byte;
    logic [2:0]         addr_m1;
    logic [PULSE_W-1:0] sync_len;
    logic [TMR_W-1:0]   to_limit;
    logic               unused_bits;

    assign busy        = (r_q.st != ST_IDLE);
    assign addr_m1     = reg_addr - 3'd1;
    assign size_ok     = (reg_wdata[24:20] != '0) && (int'(reg_wdata[24:20]) <= BYTES);
    assign unused_bits = ^{reg_wdata[18:17], reg_wdata[14:8]};

    auxch_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(r_q.st == ST_IDLE),
        .en(r_q.st == ST_SYNC), .div(r_q.div), .tick(tick)
    );

    auxch_buf #(.NWORDS(NWORDS), .IW(IW), .BIW(SZ_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .sw_we(sw_we), .sw_idx(addr_m1[IW-1:0]), .sw_data(reg_wdata),
        .rd_idx(addr_m1[IW-1:0]), .rd_word(word_rd),
        .eng_we(eng_we), .eng_idx(r_q.idx), .eng_data(rx_data), .eng_byte(eng_byte)
    );

    always_comb begin
        sync_len = r_q.fast ? PULSE_W'(FAST_PULSES)
                            : PULSE_W'(BASE_PULSES) + PULSE_W'({r_q.pre, 1'b0});
        case (r_q.to_sel)
            2'b00:   to_limit = TMR_W'(TO_SHORT);
            2'b01:   to_limit = TMR_W'(TO_MID);
            default: to_limit = TMR_W'(TO_MAX);
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.irq  = 1'b0;
        sw_we    = 1'b0;
        eng_we   = 1'b0;
        tx_valid = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (reg_wr && reg_addr == 3'd0) begin
                    if (reg_wdata[30]) r_d.done   = 1'b0;
                    if (reg_wdata[28]) r_d.to_err = 1'b0;
                    if (reg_wdata[25]) r_d.rx_err = 1'b0;
                    r_d.irq_en = reg_wdata[29];
                    r_d.to_sel = reg_wdata[27:26];
                    r_d.size   = reg_wdata[24:20];
                    r_d.fast   = reg_wdata[19];
                    r_d.pre    = reg_wdata[16:15];
                    r_d.div    = reg_wdata[DIV_W-1:0];
                    if (reg_wdata[31]) begin
                        r_d.done   = !size_ok;
                        r_d.rx_err = !size_ok;
                        r_d.to_err = 1'b0;
                        r_d.irq    = !size_ok && reg_wdata[29];
                        r_d.bad    = 1'b0;
                        r_d.idx    = '0;
                        r_d.pulses = '0;
                        if (size_ok) r_d.st = ST_SYNC;
                    end
                end else if (reg_wr && reg_addr != 3'd0 && int'(reg_addr) <= NWORDS) begin
                    sw_we = 1'b1;
                end
            end
            ST_SYNC: begin
                if (tick) begin
                    r_d.pulses = r_q.pulses + PULSE_W'(1);
                    if (r_q.pulses == sync_len - PULSE_W'(1)) r_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    if (r_q.idx == r_q.size - SZ_W'(1)) begin
                        r_d.st    = ST_WAIT;
                        r_d.idx   = '0;
                        r_d.timer = '0;
                    end else begin
                        r_d.idx = r_q.idx + SZ_W'(1);
                    end
                end
            end
            default: begin
                r_d.timer = r_q.timer + TMR_W'(1);
                if (rx_valid) begin
                    eng_we  = (int'(r_q.idx) < BYTES);
                    r_d.bad = r_q.bad || rx_bad;
                    if (int'(r_q.idx) <= BYTES) r_d.idx = r_q.idx + SZ_W'(1);
                    if (rx_last) begin
                        r_d.st     = ST_IDLE;
                        r_d.done   = 1'b1;
                        r_d.size   = r_d.idx;
                        r_d.rx_err = r_d.bad || (int'(r_q.idx) >= BYTES);
                        r_d.irq    = r_q.irq_en;
                    end
                end else if (r_q.timer == to_limit - TMR_W'(1)) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.to_err = 1'b1;
                    r_d.irq    = r_q.irq_en;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        tx_data   = eng_byte;
        tx_first  = tx_valid && (r_q.idx == '0);
        tx_last   = tx_valid && (r_q.idx == r_q.size - SZ_W'(1));
        line_sync = (r_q.st == ST_SYNC);
        irq       = r_q.irq;
        if (reg_addr == 3'd0)
            reg_rdata = {busy, r_q.done, r_q.irq_en, r_q.to_err, r_q.to_sel, r_q.rx_err,
                         r_q.size, r_q.fast, 2'b00, r_q.pre, 7'd0, 8'(r_q.div)};
        else if (int'(reg_addr) <= NWORDS)
            reg_rdata = word_rd;
        else
            reg_rdata = '0;
    end
endmodule

// File: rtl/auxch_chk.sv
module auxch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       done,
    input logic       busy,
    input logic       line_sync,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       to_err,
    input logic       rx_err,
    input logic [4:0] size
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done && !busy); // R9
    AST_SYNC_BEFORE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !line_sync); // R3
    AST_SYNC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync || tx_valid) |-> busy); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data)); // R2
    AST_GOOD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !to_err && !rx_err) |-> (size != 5'd0 && size <= 5'd20)); // R5
endmodule

bind auxch_ctrl auxch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .done(r_q.done), .busy(busy),
    .line_sync(line_sync), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .to_err(r_q.to_err), .rx_err(r_q.rx_err), .size(r_q.size)
);

// File: tb/sim_auxch_ctrl.sv
module sim_auxch_ctrl;
    localparam int TO_SHORT = 400;
    localparam int TO_MID   = 600;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, line_sync, tx_valid, tx_first, tx_last;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_bad = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;

    int checks = 0, failures = 0, irq_cnt = 0;
    logic [7:0] exp_buf [20];

    auxch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .line_sync(line_sync),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_first(tx_first),
        .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data), .rx_bad(rx_bad),
        .rx_last(rx_last)
    );

    always #2.5 clk = ~clk;
    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic st, input logic ie, input logic [1:0] sel,
                                       input int size, input logic fast, input logic [1:0] pre,
                                       input logic [7:0] dv);
        return {st, 1'b0, ie, 1'b0, sel, 1'b0, 5'(size), fast, 2'b00, pre, 7'd0, dv};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_word(input logic [2:0] a, input logic [31:0] d);
        wr(a, d);
        for (int k = 0; k < 4; k++) exp_buf[(a-1)*4+k] = d[31-8*k -: 8];
    endtask

    // Observe sync and the outgoing bytes; optional write attempt while busy.
    task automatic send_check(input int exp_sync, input int n, input bit poke, input string tag);
        int sync_cnt = 0, got = 0, guard = 0;
        logic [31:0] v;
        while (guard < 5000) begin
            guard++;
            reg_wr = 1'b0;
            if (line_sync) begin
                sync_cnt++;
                if (poke && sync_cnt == 1) begin
                    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'hDEADBEEF;
                end
                if (poke && sync_cnt == 2) begin
                    rd(3'd0, v);
                    chk("R4 busy bit during sync", 32'(v[31]), 32'd1);
                end
            end
            if (tx_valid) begin
                chk({"R2 byte ", tag}, 32'(tx_data), 32'(exp_buf[got]));
                chk("R2 first marker", 32'(tx_first), 32'(got == 0));
                chk("R2 last marker", 32'(tx_last), 32'(got == n-1));
                got++;
                if (tx_last || got >= n) begin
                    @(negedge clk);
                    break;
                end
            end
            @(negedge clk);
        end
        chk({"R3 sync cycles ", tag}, 32'(sync_cnt), 32'(exp_sync));
        chk({"R2 byte count ", tag}, 32'(got), 32'(n));
    endtask

    task automatic reply(input int n, input int bad_at);
        for (int k = 0; k < n; k++) begin
            rx_valid = 1'b1; rx_data = 8'(8'hA0 + k);
            rx_bad = (k == bad_at); rx_last = (k == n-1);
            if (k < 20) exp_buf[k] = 8'(8'hA0 + k);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_bad = 1'b0; rx_last = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); chk("R1 control after reset", v, 32'd0);
        rd(3'd3, v); chk("R1 data after reset", v, 32'd0);
        chk("R1 outputs idle", {29'd0, tx_valid, line_sync, irq}, 32'd0);
    endtask

    task automatic t_send_reply;
        logic [31:0] v;
        int base;
        set_word(3'd1, 32'h11223344);
        set_word(3'd2, 32'h55667788);
        wr(3'd0, mk(1'b1, 1'b1, 2'b00, 6, 1'b0, 2'd1, 8'd3));
        send_check(28*3, 6, 1'b1, "normal");
        rd(3'd1, v); chk("R4 data write while busy ignored", v, 32'h11223344);
        base = irq_cnt;
        reply(3, -1);
        rd(3'd0, v);
        chk("R5 busy cleared", 32'(v[31]), 32'd0);
        chk("R5 done set", 32'(v[30]), 32'd1);
        chk("R5 reply size", 32'(v[24:20]), 32'd3);
        chk("R5 no errors", {30'd0, v[28], v[25]}, 32'd0);
        rd(3'd1, v); chk("R5 reply bytes msb first", v, 32'hA0A1A244);
        chk("R9 one irq cycle", 32'(irq_cnt - base), 32'd1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(3'd0, mk(1'b0, 1'b1, 2'b00, 3, 1'b0, 2'd1, 8'd3));
        rd(3'd0, v); chk("R8 write 0 keeps done", 32'(v[30]), 32'd1);
        wr(3'd0, mk(1'b0, 1'b1, 2'b00, 3, 1'b0, 2'd1, 8'd3) | 32'h4000_0000);
        rd(3'd0, v); chk("R8 write 1 clears done", 32'(v[30]), 32'd0);
    endtask

    task automatic t_fast;
        logic [31:0] v;
        int base = irq_cnt;
        wr(3'd0, mk(1'b1, 1'b0, 2'b00, 1, 1'b1, 2'd3, 8'd0));
        send_check(18, 1, 1'b0, "fast");
        reply(1, -1);
        rd(3'd0, v);
        chk("R5 fast reply done", {v[31], v[30], v[24:20]}, {2'b01, 5'd1});
        chk("R9 no irq when disabled", 32'(irq_cnt - base), 32'd0);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        wr(3'd0, mk(1'b1, 1'b1, 2'b00, 1, 1'b0, 2'd0, 8'd1));
        send_check(26, 1, 1'b0, "short");
        repeat (TO_SHORT - 3) @(negedge clk);
        rd(3'd0, v); chk("R6 still busy before short window", 32'(v[31]), 32'd1);
        repeat (5) @(negedge clk);
        rd(3'd0, v);
        chk("R6 short timeout flags", {29'd0, v[31], v[30], v[28]}, 32'b011);
        wr(3'd0, mk(1'b1, 1'b0, 2'b01, 1, 1'b0, 2'd0, 8'd1));
        send_check(26, 1, 1'b0, "mid");
        repeat (TO_SHORT + 5) @(negedge clk);
        rd(3'd0, v); chk("R6 mid window outlasts short", 32'(v[31]), 32'd1);
        repeat (TO_MID - TO_SHORT) @(negedge clk);
        rd(3'd0, v);
        chk("R6 mid timeout flags", {29'd0, v[31], v[30], v[28]}, 32'b011);
    endtask

    task automatic t_rxerr;
        logic [31:0] v;
        wr(3'd0, mk(1'b1, 1'b0, 2'b10, 2, 1'b0, 2'd0, 8'd1));
        send_check(26, 2, 1'b0, "bad");
        reply(3, 1);
        rd(3'd0, v);
        chk("R7 malformed byte error", {30'd0, v[30], v[25]}, 32'b11);
        wr(3'd0, mk(1'b1, 1'b0, 2'b10, 2, 1'b0, 2'd0, 8'd1));
        send_check(26, 2, 1'b0, "ovf");
        reply(22, -1);
        rd(3'd0, v);
        chk("R7 overflow error", {30'd0, v[30], v[25]}, 32'b11);
        chk("R7 overflow size", 32'(v[24:20]), 32'd21);
        rd(3'd5, v); chk("R7 last word keeps bytes 16..19", v, 32'hB0B1B2B3);
    endtask

    task automatic t_badsize;
        logic [31:0] v;
        int sync_seen = 0;
        wr(3'd0, mk(1'b1, 1'b0, 2'b00, 0, 1'b0, 2'd0, 8'd1));
        if (line_sync || tx_valid) sync_seen++;
        rd(3'd0, v);
        chk("R10 size 0 rejected", {29'd0, v[31], v[30], v[25]}, 32'b011);
        wr(3'd0, mk(1'b1, 1'b0, 2'b00, 21, 1'b0, 2'd0, 8'd1));
        if (line_sync || tx_valid) sync_seen++;
        rd(3'd0, v);
        chk("R10 size 21 rejected", {29'd0, v[31], v[30], v[25]}, 32'b011);
        repeat (3) @(negedge clk) if (line_sync || tx_valid) sync_seen++;
        chk("R10 no sync or bytes", 32'(sync_seen), 32'd0);
    endtask

    initial begin
        for (int k = 0; k < 20; k++) exp_buf[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send_reply();
        t_w1c();
        t_fast();
        t_timeout();
        t_rxerr();
        t_badsize();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule